// File: doc/BRIEF.md
# Block-Transfer DMA Request and Interrupt Controller

This block sits in the host interface of a flash storage device. It drives an active-low interrupt line and an active-low DMA request line toward the host while data moves block by block. A host operation is started with a direction (read or write), a DMA selection and a byte length. The data buffer then reports each block with a ready strobe, and reports with a done strobe when the host has moved that block. The block counts finished blocks and ends the operation after the last one.

Two register-style inputs control the outputs. A control write loads an interrupt enable bit and a request-style bit. A clear strobe releases a held interrupt. Without DMA, the host is interrupted block by block. With DMA, the request line serves each block, and one interrupt marks the end of the whole operation.

Top module: `blkxfer_irq_dma`

## Requirements
- R1: After reset `irq_n` and `dmarq_n` are high, `busy` and `op_done` are low, `blk_cnt` is 0, and interrupts are disabled with level request style.
- R2: `op_start` is accepted only while `busy` is low. It sets `blk_cnt` to 0 and captures the direction, the DMA selection and the length. The block total is the byte length divided by 512 and rounded up; a length of 0 counts as one block, and any total above 256 blocks (128 KB) is capped to 256. `blk_cnt` counts completed blocks. After the done strobe of the last block, `busy` falls and `op_done` pulses high for exactly one cycle.
- R3: In a read without DMA, every accepted block-ready strobe raises the interrupt in the following cycle.
- R4: In a write without DMA, every accepted block-ready strobe raises the interrupt except the one for the first block of the operation.
- R5: In a DMA operation, block-ready strobes raise no interrupt. The done strobe of the last block raises the interrupt together with the fall of `busy`.
- R6: Once low, `irq_n` stays low until `irq_clr` is pulsed. If a clear and a new interrupt event fall in the same cycle, `irq_n` stays low.
- R7: When the enable bit is 0, interrupt events are dropped. They are not latched, so setting the enable later does not lower `irq_n`.
- R8: Level style (`ctl_edge`=0): during a DMA operation `dmarq_n` is low from the cycle after an accepted ready strobe until the cycle after that block's done strobe.
- R9: Edge style (`ctl_edge`=1): each accepted ready strobe gives a `dmarq_n` low pulse of exactly one cycle. A ready strobe that arrives before the previous block's done strobe is ignored and gives no pulse.
- R10: In an operation without DMA, `dmarq_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe; loads `ctl_irq_en` and `ctl_edge` |
| ctl_irq_en | input | 1 | Interrupt enable bit |
| ctl_edge | input | 1 | DMA request style: 1 pulse per block, 0 held level |
| irq_clr | input | 1 | Interrupt clear strobe |
| op_start | input | 1 | Start a new operation |
| op_read | input | 1 | Direction: 1 read, 0 write |
| op_dma | input | 1 | 1 selects DMA transfer |
| op_len | input | LEN_W (18) | Operation length in bytes |
| blk_ready | input | 1 | Buffer has a block ready to send or room to accept one |
| blk_done | input | 1 | Host has transferred the current block |
| irq_n | output | 1 | Active-low level interrupt |
| dmarq_n | output | 1 | Active-low DMA request |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle pulse when the operation completes |
| blk_cnt | output | CNT_W (9) | Completed blocks in the current or last operation |

## Verification
The bench checks that a write does not interrupt on its first block but does on every later one. A design that counted from the wrong block would interrupt too early or miss the second block. It also checks a clear that lands in the same cycle as a new event; a design that gave the clear priority would lose that interrupt. Edge-style requests are checked for width and for a second ready strobe sent before the done strobe: a wrong design would stretch the pulse or issue an extra request for a block that does not exist. Lengths above 128 KB, a zero length, and an `op_start` while busy check the capping and the end of the operation, where a design that got them wrong would run past 256 blocks, hang, or corrupt a running transfer.

// File: rtl/blkxfer_irq_dma.sv
module blkxfer_irq_dma #(
  parameter int BLK_LOG2 = 9,
  parameter int MAX_BLKS = 256,
  parameter int LEN_W    = 18,
  localparam int CNT_W   = $clog2(MAX_BLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_irq_en,
  input  logic             ctl_edge,
  input  logic             irq_clr,
  input  logic             op_start,
  input  logic             op_read,
  input  logic             op_dma,
  input  logic [LEN_W-1:0] op_len,
  input  logic             blk_ready,
  input  logic             blk_done,
  output logic             irq_n,
  output logic             dmarq_n,
  output logic             busy,
  output logic             op_done,
  output logic [CNT_W-1:0] blk_cnt
);
  localparam int SUM_W = LEN_W + 1;

  logic             irq_en, edge_sel;
  logic             active, is_rd, is_dma, pending, dpulse, irq_q, done_q;
  logic [CNT_W-1:0] cnt, total, total_nxt, cnt_inc;
  logic [SUM_W-1:0] len_up, blks_w;
  logic             accept, finish, blk_ev, cmp_ev, set_ev;

  assign len_up  = {1'b0, op_len} + SUM_W'((1 << BLK_LOG2) - 1);
  assign blks_w  = len_up >> BLK_LOG2;
  assign cnt_inc = cnt + CNT_W'(1);

  always_comb begin
    if (blks_w == '0)                    total_nxt = CNT_W'(1);
    else if (blks_w > SUM_W'(MAX_BLKS))  total_nxt = CNT_W'(MAX_BLKS);
    else                                 total_nxt = blks_w[CNT_W-1:0];
  end

  assign accept = active & blk_ready & ~pending;
  assign finish = active & pending & blk_done & (cnt_inc == total);
  assign blk_ev = accept & ~is_dma & (is_rd | (cnt != '0));
  assign cmp_ev = finish & is_dma;
  assign set_ev = irq_en & (blk_ev | cmp_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en   <= 1'b0;
      edge_sel <= 1'b0;
    end else if (ctl_wr) begin
      irq_en   <= ctl_irq_en;
      edge_sel <= ctl_edge;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      is_rd   <= 1'b0;
      is_dma  <= 1'b0;
      total   <= '0;
      cnt     <= '0;
      pending <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (op_start && !active) begin
        active  <= 1'b1;
        is_rd   <= op_read;
        is_dma  <= op_dma;
        total   <= total_nxt;
        cnt     <= '0;
        pending <= 1'b0;
      end else if (accept) begin
        pending <= 1'b1;
      end else if (active && pending && blk_done) begin
        pending <= 1'b0;
        cnt     <= cnt_inc;
        if (finish) active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      dpulse <= 1'b0;
    end else begin
      irq_q  <= set_ev | (irq_q & ~irq_clr);
      dpulse <= accept & is_dma & edge_sel;
    end
  end

  assign irq_n   = ~irq_q;
  assign dmarq_n = ~(dpulse | (active & is_dma & ~edge_sel & pending));
  assign busy    = active;
  assign op_done = done_q;
  assign blk_cnt = cnt;
endmodule

// File: rtl/blkxfer_irq_dma_chk.sv
module blkxfer_irq_dma_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_n,
  input logic             dmarq_n,
  input logic             irq_clr,
  input logic             irq_en,
  input logic             edge_sel,
  input logic             ctl_wr,
  input logic             is_dma,
  input logic             active,
  input logic             op_done,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] total
);
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !irq_clr) |=> !irq_n);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && !irq_en) |=> irq_n);

  // R9
  edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dmarq_n && edge_sel && !ctl_wr) |=> dmarq_n);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < total));

  // R2
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> ($past(active) && !active));

  // R10
  no_dma_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_dma |-> dmarq_n);
endmodule

bind blkxfer_irq_dma blkxfer_irq_dma_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .dmarq_n(dmarq_n),
  .irq_clr(irq_clr), .irq_en(irq_en), .edge_sel(edge_sel), .ctl_wr(ctl_wr),
  .is_dma(is_dma), .active(active), .op_done(op_done), .cnt(cnt), .total(total)
);

// File: tb/blkxfer_irq_dma_bench.sv
module blkxfer_irq_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 0, ctl_irq_en = 0, ctl_edge = 0, irq_clr = 0;
  logic        op_start = 0, op_read = 0, op_dma = 0;
  logic [17:0] op_len = '0;
  logic        blk_ready = 0, blk_done = 0;
  logic        irq_n, dmarq_n, busy, op_done;
  logic [8:0]  blk_cnt;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  blkxfer_irq_dma u_blkxfer_irq_dma (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_irq_en(ctl_irq_en),
    .ctl_edge(ctl_edge), .irq_clr(irq_clr), .op_start(op_start),
    .op_read(op_read), .op_dma(op_dma), .op_len(op_len),
    .blk_ready(blk_ready), .blk_done(blk_done), .irq_n(irq_n),
    .dmarq_n(dmarq_n), .busy(busy), .op_done(op_done), .blk_cnt(blk_cnt)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(logic en, logic edg);
    ctl_wr = 1; ctl_irq_en = en; ctl_edge = edg;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic start(logic rd, logic dma, int len);
    op_start = 1; op_read = rd; op_dma = dma; op_len = 18'(len);
    @(negedge clk); op_start = 0;
  endtask

  task automatic ready();  blk_ready = 1; @(negedge clk); blk_ready = 0; endtask
  task automatic done();   blk_done  = 1; @(negedge clk); blk_done  = 0; endtask
  task automatic clr();    irq_clr   = 1; @(negedge clk); irq_clr   = 0; endtask

  task automatic t_reset();
    check("R1 irq_n", irq_n, 1);
    check("R1 dmarq_n", dmarq_n, 1);
    check("R1 busy", busy, 0);
    check("R1 op_done", op_done, 0);
    check("R1 blk_cnt", blk_cnt, 0);
  endtask

  task automatic t_read_pio();
    cfg(1, 0);
    start(1, 0, 1024);
    check("R2 busy after start", busy, 1);
    ready();
    check("R3 irq on block 1", irq_n, 0);
    check("R10 dmarq_n idle", dmarq_n, 1);
    repeat (3) @(negedge clk);
    check("R6 irq held", irq_n, 0);
    done(); clr();
    check("R6 irq cleared", irq_n, 1);
    ready();
    check("R3 irq on block 2", irq_n, 0);
    clr(); done();
    check("R2 op_done pulse", op_done, 1);
    check("R2 busy low", busy, 0);
    check("R2 blk_cnt 2", blk_cnt, 2);
    check("R5 no completion irq w/o dma", irq_n, 1);
    @(negedge clk);
    check("R2 op_done one cycle", op_done, 0);
  endtask

  task automatic t_write_pio();
    start(0, 0, 1536);
    ready();
    check("R4 first block no irq", irq_n, 1);
    done(); ready();
    check("R4 second block irq", irq_n, 0);
    clr(); done(); ready();
    check("R4 third block irq", irq_n, 0);
    clr(); done();
    check("R2 write ends", busy, 0);
    check("R2 blk_cnt 3", blk_cnt, 3);
  endtask

  task automatic t_dma_level();
    cfg(1, 0);
    start(1, 1, 1000);
    ready();
    check("R8 request low", dmarq_n, 0);
    check("R5 no block irq", irq_n, 1);
    @(negedge clk);
    check("R8 request held", dmarq_n, 0);
    done();
    check("R8 request released", dmarq_n, 1);
    check("R5 no irq mid op", irq_n, 1);
    ready(); done();
    check("R5 completion irq", irq_n, 0);
    check("R5 busy falls", busy, 0);
    check("R2 op_done dma", op_done, 1);
    clr();
  endtask

  task automatic t_dma_edge();
    cfg(1, 1);
    start(0, 1, 512);
    ready();
    check("R9 pulse low", dmarq_n, 0);
    @(negedge clk);
    check("R9 pulse one cycle", dmarq_n, 1);
    ready();
    check("R9 no pulse before done", dmarq_n, 1);
    @(negedge clk);
    check("R9 still no pulse", dmarq_n, 1);
    done();
    check("R5 edge completion irq", irq_n, 0);
    check("R2 blk_cnt 1", blk_cnt, 1);
    clr();
  endtask

  task automatic t_disabled();
    cfg(0, 0);
    start(1, 0, 512);
    ready();
    check("R7 no irq disabled", irq_n, 1);
    done();
    cfg(1, 0);
    @(negedge clk);
    check("R7 not latched", irq_n, 1);
  endtask

  task automatic t_clear_collide();
    cfg(1, 0);
    start(1, 0, 1024);
    ready(); done();
    irq_clr = 1; blk_ready = 1;
    @(negedge clk); irq_clr = 0; blk_ready = 0;
    check("R6 set beats clear", irq_n, 0);
    clr();
    check("R6 clear alone", irq_n, 1);
    done();
    check("R2 collide op ends", busy, 0);
  endtask

  task automatic t_cap();
    cfg(1, 0);
    start(1, 1, 200000);
    for (int i = 0; i < 255; i++) begin ready(); done(); end
    check("R2 busy after 255", busy, 1);
    ready(); done();
    check("R2 capped 256 ends", busy, 0);
    check("R2 blk_cnt 256", blk_cnt, 256);
    clr();
    start(1, 0, 0);
    ready(); clr(); done();
    check("R2 zero len one block", busy, 0);
    check("R2 zero len cnt", blk_cnt, 1);
  endtask

  task automatic t_start_busy();
    start(1, 0, 512);
    start(0, 1, 2048);
    ready();
    check("R2 restart ignored irq", irq_n, 0);
    check("R2 restart ignored dma", dmarq_n, 1);
    clr(); done();
    check("R2 restart ignored end", busy, 0);
    check("R2 restart ignored cnt", blk_cnt, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read_pio();
        t_write_pio();
        t_dma_level();
        t_dma_edge();
        t_disabled();
        t_clear_collide();
        t_cap();
        t_start_busy();
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule